// File: doc/BRIEF.md
# Byte-Stepped I2C Master with Register Control

This block is a bus master for a two-wire serial bus. Software programs it through four byte-wide registers: a configuration register, a command/status register, an own-address register and a data register. One command issues a START and shifts out the byte in the data register. After the acknowledge clock of every byte, the block raises a pending flag and holds the clock line low. It resumes when software clears that flag. Software therefore moves one byte per handshake and can load the next byte, switch to receive, ask for a repeated START or ask for a STOP before it releases the bus.

Both bus lines are open-drain. The block only pulls a line low or releases it. It reads the wire levels back through two-stage synchronizers, which feed the bit sampler, the bus-busy detector and a check for a lost bus. The bit clock comes from the system clock through a fixed prescaler of 16 or 512, followed by a 4-bit divisor.

Top module: `i2c_regmaster`

## Requirements
- R1: After reset, all four registers read 0, both bus lines are released (`scl_lo`=0, `sda_lo`=0) and `irq` is 0.
- R2: The SCL period in clock cycles equals P*(D+1). P is 16 when configuration bit 6 is 0 and 512 when it is 1. D is configuration bits 3:0.
- R3: In the idle state, a command write with bits 7 and 5 both 1 and bit 4 (output enable) set produces a START and then the data-register byte, MSB first. The same write with bit 4 clear leaves both lines released and issues no START.
- R4: After the ninth clock of each byte, configuration bit 4 (pending) reads 1 and SCL stays low until software writes configuration bit 4 as 0. Writing 1 to that bit never sets it. `irq` equals pending AND configuration bit 5.
- R5: For a transmitted byte, command bit 0 reads 1 when the receiver did not acknowledge and 0 when it did.
- R6: For a received byte, register 3 holds the byte when pending rises. The master drives ACK (SDA low) on the ninth clock when configuration bit 7 is 1 and NACK when it is 0.
- R7: A command write with bit 5 = 0 while pending, followed by clearing pending, produces a STOP. After the STOP both lines are released.
- R8: A command write with bits 7 and 5 set while pending, followed by clearing pending, produces a repeated START without a STOP and then sends the data-register byte. Command bits 7:6 = 10 select receive for the bytes after that address byte. Bits 7:6 = 11 select transmit.
- R9: Command bit 5 reads 1 after a START is seen on the bus and 0 after a STOP is seen.
- R10: If SDA reads low during a transmitted bit the master left high, command bit 3 reads 1, both lines are released and pending sets. The next START clears bit 3.
- R11: Register select 0 is configuration, 1 is command/status, 2 is own address (read back as written) and 3 is data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| irq | output | 1 | Interrupt request |
| scl_in | input | 1 | SCL wire level |
| sda_in | input | 1 | SDA wire level |
| scl_lo | output | 1 | Pull SCL low when 1 |
| sda_lo | output | 1 | Pull SDA low when 1 |

## Verification
A wrong sequencer phase shows up on the wires within one quarter of a bit period. It appears as an SDA edge while SCL is high (a false START or STOP, which the bus model counts), or as a byte the bus model logs with wrong bits. A wrong divider shows up as an exact cycle-count error between two SCL rises in the same byte. A lost pending or acknowledge state shows up at the next register read as a wrong pending, not-acknowledged or busy bit, or as the bus model recording the wrong acknowledge on a received byte.

// File: rtl/i2c_regmaster.sv
module i2c_regmaster #(
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 512
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_sel,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_lo,
  output logic       sda_lo
);
  localparam int QLO  = PRE_LO / 4;
  localparam int QHI  = PRE_HI / 4;
  localparam int QMAX = QHI * 16;
  localparam int CW   = $clog2(QMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_BIT, S_HOLD, S_STOP, S_RST} st_t;
  st_t st;

  logic          ack_en, pre_hi, irq_en, pend;
  logic [3:0]    div;
  logic [1:0]    mode;
  logic          oe, arb, nack, busy;
  logic [7:0]    own, sh;
  logic          stop_req, rst_req, txb;
  logic [1:0]    q;
  logic [3:0]    bitn;
  logic [CW-1:0] cnt, qbase, qlen;
  logic [1:0]    scl_sy, sda_sy;
  logic          scl_d, sda_d;
  logic          scl_s, sda_s, running, tick, go;

  assign scl_s   = scl_sy[1];
  assign sda_s   = sda_sy[1];
  assign qbase   = pre_hi ? CW'(QHI) : CW'(QLO);
  assign qlen    = qbase * ({{(CW-4){1'b0}}, div} + CW'(1));
  assign running = (st != S_IDLE) && (st != S_HOLD);
  assign tick    = running && (cnt == qlen - CW'(1));
  assign go      = reg_wr && reg_sel == 2'd1 && reg_wdata[7] && reg_wdata[5]
                   && reg_wdata[4] && st == S_IDLE;
  assign irq     = pend & irq_en;

  always_comb
    case (reg_sel)
      2'd0:    reg_rdata = {ack_en, pre_hi, irq_en, pend, div};
      2'd1:    reg_rdata = {mode, busy, oe, arb, 2'b00, nack};
      2'd2:    reg_rdata = own;
      default: reg_rdata = sh;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11;
      scl_d  <= 1'b1;  sda_d  <= 1'b1;
      busy   <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
      if (scl_s && scl_d && sda_d && !sda_s)      busy <= 1'b1;
      else if (scl_s && scl_d && !sda_d && sda_s) busy <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                cnt <= '0;
    else if (!running || tick) cnt <= '0;
    else                       cnt <= cnt + CW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;
      {ack_en, pre_hi, irq_en, pend} <= 4'b0;
      div <= '0; mode <= '0; oe <= 1'b0; arb <= 1'b0; nack <= 1'b0;
      own <= '0; sh <= '0;
      stop_req <= 1'b0; rst_req <= 1'b0; txb <= 1'b0;
      q <= '0; bitn <= '0;
      scl_lo <= 1'b0; sda_lo <= 1'b0;
    end else begin
      if (reg_wr)
        case (reg_sel)
          2'd0: begin
            ack_en <= reg_wdata[7];
            pre_hi <= reg_wdata[6];
            irq_en <= reg_wdata[5];
            div    <= reg_wdata[3:0];
            if (!reg_wdata[4]) pend <= 1'b0;
          end
          2'd1: begin
            mode <= reg_wdata[7:6];
            oe   <= reg_wdata[4];
            if (st == S_HOLD) begin
              stop_req <= !reg_wdata[5];
              rst_req  <= reg_wdata[5] && reg_wdata[7];
            end
          end
          2'd2: own <= reg_wdata;
          default: if (st == S_IDLE || st == S_HOLD) sh <= reg_wdata;
        endcase

      case (st)
        S_IDLE:
          if (go) begin
            st <= S_START; q <= '0; arb <= 1'b0;
          end
        S_START:
          if (tick) begin
            if (q == 2'd0) begin
              sda_lo <= 1'b1; q <= 2'd1;
            end else begin
              scl_lo <= 1'b1; st <= S_BIT; q <= '0; bitn <= '0; txb <= 1'b1;
            end
          end
        S_BIT:
          if (tick) begin
            q <= q + 2'd1;
            case (q)
              2'd0: sda_lo <= (bitn == 4'd8) ? (!txb && ack_en) : (txb && !sh[7]);
              2'd1: scl_lo <= 1'b0;
              2'd2:
                if (bitn == 4'd8) begin
                  if (txb) nack <= sda_s;
                end else if (txb && sh[7] && !sda_s) begin
                  arb <= 1'b1; pend <= 1'b1;
                  scl_lo <= 1'b0; sda_lo <= 1'b0; st <= S_IDLE;
                end else
                  sh <= {sh[6:0], sda_s};
              default: begin
                scl_lo <= 1'b1;
                if (bitn == 4'd8) begin
                  sda_lo <= 1'b0; pend <= 1'b1; st <= S_HOLD;
                end else
                  bitn <= bitn + 4'd1;
              end
            endcase
          end
        S_HOLD:
          if (!pend) begin
            q <= '0; stop_req <= 1'b0; rst_req <= 1'b0;
            if (stop_req)     st <= S_STOP;
            else if (rst_req) st <= S_RST;
            else begin
              st <= S_BIT; bitn <= '0; txb <= (mode == 2'b11);
            end
          end
        S_STOP:
          if (tick) begin
            q <= q + 2'd1;
            case (q)
              2'd0:    sda_lo <= 1'b1;
              2'd1:    scl_lo <= 1'b0;
              2'd2:    sda_lo <= 1'b0;
              default: st <= S_IDLE;
            endcase
          end
        S_RST:
          if (tick) begin
            q <= q + 2'd1;
            case (q)
              2'd0: sda_lo <= 1'b0;
              2'd1: scl_lo <= 1'b0;
              2'd2: sda_lo <= 1'b1;
              default: begin
                scl_lo <= 1'b1; st <= S_BIT; bitn <= '0; txb <= 1'b1;
              end
            endcase
          end
        default: st <= S_IDLE;
      endcase
    end
endmodule

module i2c_regmaster_chk (
  input logic clk,
  input logic rst_n,
  input logic idle,
  input logic starting,
  input logic in_bit,
  input logic hold,
  input logic pend,
  input logic arb,
  input logic scl_lo,
  input logic sda_lo
);
  p_idle_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (!scl_lo && !sda_lo));
  p_hold_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> scl_lo);
  p_pend_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> (scl_lo || arb));
  p_start_scl_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    starting |-> !scl_lo);
  p_sda_moves_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bit && !$stable(sda_lo)) |-> scl_lo);
  p_arb_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb) |-> (!scl_lo && !sda_lo));
endmodule

bind i2c_regmaster i2c_regmaster_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .idle(st == S_IDLE), .starting(st == S_START),
  .in_bit(st == S_BIT), .hold(st == S_HOLD),
  .pend(pend), .arb(arb), .scl_lo(scl_lo), .sda_lo(sda_lo)
);

// File: tb/tb_i2c_regmaster.sv
module tb_i2c_regmaster;
  localparam int CLK_NS = 10;
  localparam int LIMIT  = 190000;
  localparam logic [6:0] SLV = 7'h2A;

  logic clk = 0, rst_n = 0;
  logic [1:0] reg_sel = '0;
  logic reg_wr = 0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic irq, scl_lo, sda_lo, scl_w, sda_w;
  logic s_drv = 0, rival_lo = 0;

  assign scl_w = !scl_lo;
  assign sda_w = !sda_lo && !s_drv && !rival_lo;

  i2c_regmaster dut (.clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_in(scl_w), .sda_in(sda_w), .scl_lo(scl_lo), .sda_lo(sda_lo));

  always #(CLK_NS/2) clk = !clk;

  int total = 0, fails = 0, cyc = 0, t_prev = 0, t_last = 0, n_rise = 0;
  always @(posedge clk) cyc++;
  always @(posedge scl_w) begin t_prev = t_last; t_last = cyc; n_rise++; end

  function automatic logic rbit(input int k, input int b);
    logic [7:0] v;
    v = 8'(8'hA5 ^ (k * 37));
    return v[b];
  endfunction

  logic s_act = 0, s_first = 0, s_rw = 0, s_sel = 0;
  logic [7:0] s_sh = '0;
  int s_bit = 0, s_byte = 0, n_start = 0, n_stop = 0, n_wr = 0;
  logic [7:0] wr_log [8];
  logic mack [8];

  always @(negedge sda_w) if (scl_w) begin
    s_act = 1; s_first = 1; s_bit = 0; s_byte = 0; n_start++;
  end
  always @(posedge sda_w) if (scl_w && s_act) begin
    s_act = 0; s_drv = 0; n_stop++;
  end
  always @(posedge scl_w) if (s_act && !s_first) begin
    if (s_bit < 8) s_sh = {s_sh[6:0], sda_w};
    else if (s_byte > 0 && s_byte <= 8 && s_rw && s_sel) mack[s_byte-1] = sda_w;
  end
  always @(negedge scl_w) if (s_act) begin
    if (s_first) s_first = 0;
    else if (s_bit < 7) begin
      s_bit++;
      s_drv = (s_byte > 0 && s_rw && s_sel) ? !rbit(s_byte-1, 7-s_bit) : 1'b0;
    end else if (s_bit == 7) begin
      s_bit = 8;
      if (s_byte == 0) begin
        s_rw = s_sh[0]; s_sel = (s_sh[7:1] == SLV); s_drv = s_sel;
      end else if (!s_rw) begin
        if (s_sel && n_wr < 8) begin wr_log[n_wr] = s_sh; n_wr++; end
        s_drv = s_sel;
      end else s_drv = 0;
    end else begin
      s_bit = 0; s_byte++;
      s_drv = (s_rw && s_sel && (s_byte == 1 || !mack[s_byte-2])) ? !rbit(s_byte-1, 7) : 1'b0;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) if (cyc > LIMIT) begin
    total++; fails++;
    $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cyc, LIMIT);
    summary();
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    @(negedge clk); reg_sel = s; #1 v = reg_rdata;
  endtask

  task automatic wait_pend();
    logic [7:0] v;
    do rd(2'd0, v); while (!v[4]);
  endtask

  logic [7:0] cfgv = '0;

  task automatic stop_bus(input logic [7:0] cmd);
    logic [7:0] v;
    wr(2'd1, cmd);
    wr(2'd0, cfgv);
    do rd(2'd1, v); while (v[5]);
    repeat (300) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    int s0, p0, w0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset values
    rd(2'd0, v); check("R1 cfg", v, 8'h00);
    rd(2'd1, v); check("R1 status", v, 8'h00);
    rd(2'd3, v); check("R1 data", v, 8'h00);
    rd(2'd2, v); check("R1 own", v, 8'h00);
    check("R1 lines", {scl_lo, sda_lo, irq}, 3'b000);

    // R11 own address readback
    wr(2'd2, 8'h6C); rd(2'd2, v); check("R11 own", v, 8'h6C);
    rd(2'd3, v); check("R11 data untouched", v, 8'h00);

    // R4 pending cannot be set by software
    wr(2'd0, 8'h13); rd(2'd0, v); check("R4 pend not settable", v, 8'h03);

    // R3 START gated by output enable
    s0 = n_start;
    wr(2'd1, 8'hE0);
    repeat (200) @(negedge clk);
    check("R3 no start without oe", {scl_lo, sda_lo}, 2'b00);
    check("R3 no start seen", n_start - s0, 0);
    rd(2'd1, v); check("R9 idle not busy", v[5], 1'b0);

    // R2 divider sweep, R5 unmatched address NACK
    for (int pre = 0; pre < 2; pre++)
      for (int d = 0; d < (pre ? 2 : 16); d++) begin
        cfgv = {1'b1, 1'(pre), 1'b1, 1'b0, 4'(d)};
        wr(2'd0, cfgv);
        wr(2'd3, 8'h22);
        wr(2'd1, 8'hF0);
        wait_pend();
        check("R2 scl period", t_last - t_prev, (pre ? 512 : 16) * (d + 1));
        rd(2'd1, v); check("R5 nack on no device", v[0], 1'b1);
        check("R4 irq with pending", irq, 1'b1);
        stop_bus(8'hD0);
        check("R4 irq cleared", irq, 1'b0);
      end

    // Write transfer
    cfgv = 8'hA1; wr(2'd0, cfgv);
    s0 = n_start; p0 = n_stop; w0 = n_wr;
    wr(2'd3, {SLV, 1'b0});
    wr(2'd1, 8'hF0);
    wait_pend();
    rd(2'd1, v); check("R5 ack on address", v[0], 1'b0);
    check("R9 busy after start", v[5], 1'b1);
    r0 = n_rise;
    repeat (300) @(negedge clk);
    check("R4 scl held low", {scl_lo, n_rise - r0}, {1'b1, 32'd0});
    for (int k = 0; k < 3; k++) begin
      wr(2'd3, (k == 0) ? 8'h3C : (k == 1) ? 8'hFF : 8'h00);
      wr(2'd0, cfgv);
      wait_pend();
      rd(2'd1, v); check("R5 ack on data", v[0], 1'b0);
    end
    stop_bus(8'hD0);
    check("R3 bytes written", n_wr - w0, 3);
    check("R3 byte0 msb first", wr_log[w0], 8'h3C);
    check("R3 byte1", wr_log[w0+1], 8'hFF);
    check("R3 byte2", wr_log[w0+2], 8'h00);
    check("R7 one stop", n_stop - p0, 1);
    check("R7 one start", n_start - s0, 1);
    check("R7 released", {scl_lo, sda_lo}, 2'b00);
    rd(2'd1, v); check("R9 busy cleared", v[5], 1'b0);

    // Read transfer with NACK on final byte
    cfgv = 8'hA1; wr(2'd0, cfgv);
    wr(2'd3, {SLV, 1'b1});
    wr(2'd1, 8'hB0);
    wait_pend();
    rd(2'd1, v); check("R5 ack on read address", v[0], 1'b0);
    for (int k = 0; k < 3; k++) begin
      if (k == 2) cfgv = 8'h21;
      wr(2'd0, cfgv);
      wait_pend();
      rd(2'd3, v); check("R6 received byte", v, 8'(8'hA5 ^ (k * 37)));
    end
    check("R6 ack byte0", mack[0], 1'b0);
    check("R6 ack byte1", mack[1], 1'b0);
    check("R6 nack last", mack[2], 1'b1);
    stop_bus(8'h90);

    // R8 repeated start: write one byte then read one byte
    cfgv = 8'hA1; wr(2'd0, cfgv);
    s0 = n_start; p0 = n_stop; w0 = n_wr;
    wr(2'd3, {SLV, 1'b0});
    wr(2'd1, 8'hF0);
    wait_pend();
    wr(2'd3, 8'h77); wr(2'd0, cfgv); wait_pend();
    wr(2'd1, 8'hB0);
    wr(2'd3, {SLV, 1'b1});
    wr(2'd0, cfgv);
    wait_pend();
    rd(2'd1, v); check("R8 ack after restart", v[0], 1'b0);
    check("R8 two starts", n_start - s0, 2);
    check("R8 no stop between", n_stop - p0, 0);
    cfgv = 8'h21; wr(2'd0, cfgv); wait_pend();
    rd(2'd3, v); check("R8 read after restart", v, 8'hA5);
    check("R8 written byte", wr_log[w0], 8'h77);
    stop_bus(8'h90);
    check("R8 final stop", n_stop - p0, 1);

    // R10 arbitration loss
    cfgv = 8'h21; wr(2'd0, cfgv);
    wr(2'd3, 8'hFE);
    wr(2'd1, 8'hF0);
    do @(negedge clk); while (scl_w);
    rival_lo = 1;
    wait_pend();
    rd(2'd1, v); check("R10 arb flag", v[3], 1'b1);
    check("R10 released", {scl_lo, sda_lo}, 2'b00);
    rival_lo = 0;
    repeat (20) @(negedge clk);
    rd(2'd1, v); check("R9 busy after rival stop", v[5], 1'b0);
    wr(2'd0, cfgv);
    wr(2'd3, {SLV, 1'b0});
    wr(2'd1, 8'hF0);
    wait_pend();
    rd(2'd1, v); check("R10 arb cleared by start", {v[3], v[0]}, 2'b00);
    stop_bus(8'hD0);

    summary();
  end
endmodule